// File: doc/BRIEF.md
# Processor bus region decoder

This block sits between one processor's memory request port and a set of simple target ports. It takes a 32-bit address and splits the address space into 32 coarse regions. The region index takes address bits 31:29 as its upper three bits and the two chip-select lines, address bits 26:25, as its lower two. Each region is either routed to one target or left unmapped. The cached and uncached views of the same memory are aliases: region n and region n+4 (n = 0..3) decode to the same target. Inside the first chip-select window there is a second decode level that splits system registers, video registers and palette RAM away from boot ROM.

Every access runs on a big-endian 16-bit data path. A byte access picks one lane of a halfword cycle. A 32-bit access becomes two halfword cycles: the first at the word address, which carries the high half, and the second two bytes above it. The one exception is the on-chip peripheral region, which takes a single native 32-bit cycle.

Each target cycle is a one-cycle strobe with a one-hot target select, a masked offset, a byte-enable pair and the write data. Read data must come back on `tgt_rdata` exactly `LAT` cycles after the strobe. Requests use a valid/ready handshake. `req_ready` is high only while the block is idle, so a requester facing a low `req_ready` holds its request fields stable until it sees ready. The response is a one-cycle `rsp_valid` pulse with no back-pressure.

Top module: `bus_region_decoder`

## Requirements
- R1: The region index is {addr[31:29], addr[26:25]}. Address bits 28:27 have no effect. Regions n and n+4 (n = 0..3) select the same target with the same offset.
- R2: `tgt_sel` is one-hot, with this bit order: 0 boot ROM, 1 system registers, 2 video registers, 3 palette, 4 cartridge ROM, 5 frame buffer, 6 SDRAM, 7 data array of processor 0, 8 data array of processor 1, 9 peripherals. The region-to-target map is: regions 1/5 go to cartridge ROM (offset addr[21:0]); regions 2/6 go to the frame buffer (offset addr[16:0]); regions 3/7 go to SDRAM (offset addr[17:0]); region 0x18 goes to the data array chosen by `req_cpu` (offset addr[11:0]); region 0x1F goes to the peripherals (offset addr[8:0]). All other regions are unmapped.
- R3: In regions 0/4, a read decodes on addr[17:8]. The value 0x40 selects system registers and 0x41 selects video registers, both with offset addr[7:0]. The value 0x42 selects palette, with offset addr[8:0]. Any other value selects boot ROM, with offset addr[13:0].
- R4: In regions 0/4, a palette write decodes on addr[17:9] == 0x21. Writes with addr[17:8] of either 0x42 or 0x43 therefore reach the palette. System and video register writes decode exactly as reads do.
- R5: A write to boot ROM or cartridge ROM is discarded. This covers any region 0/4 write that is not a register or palette write, and any region 1/5 write. No strobe is issued, and the response still arrives.
- R6: An access to an unmapped region issues no strobe. A read of an unmapped region returns zero. `rsp_rdata` is also zero after any write.
- R7: For a byte access, an even address gives `tgt_be` = 2'b10 and an odd address gives 2'b01. `tgt_be[1]` is the lane on bits 15:8. The write data is the byte repeated in both lanes, with bits 31:16 zero. A byte read returns the selected lane, zero-extended.
- R8: `req_size` is encoded as 0 for byte, 1 for halfword, and 2 or 3 for 32-bit. For every halfword cycle `tgt_offs[0]` is zero and `tgt_wdata[31:16]` is zero. A halfword access uses `tgt_be` = 2'b11, and its read returns `tgt_rdata[15:0]` zero-extended.
- R9: A 32-bit access outside region 0x1F makes two strobes. The first is at the address with bits 1:0 cleared and carries `req_wdata[31:16]`. The second is at that address plus 2 and carries `req_wdata[15:0]`. The read result is {first `tgt_rdata[15:0]`, second `tgt_rdata[15:0]`}.
- R10: A 32-bit access to region 0x1F makes exactly one strobe with `tgt_wide` = 1. Its offset has bits 1:0 clear, it uses `tgt_be` = 2'b11 and carries the full 32-bit write data, and its read returns all 32 bits of `tgt_rdata`. `tgt_wide` is 0 for every other cycle.
- R11: Read data is taken from `tgt_rdata` LAT cycles after the strobe. The count is from acceptance (the edge where `req_valid` and `req_ready` are both high) to the edge that raises `rsp_valid`. A mapped single-cycle access takes LAT+1 cycles, a split access 2*(LAT+1) cycles, and an unmapped or discarded access 1 cycle. Two strobes are never adjacent.
- R12: After reset `req_ready` is 1 and `rsp_valid` and `tgt_strobe` are 0. `req_ready` is 0 from acceptance until `rsp_valid` has been high. `rsp_valid` lasts one cycle. `tgt_write` and `tgt_cpu` carry the accepted request's write flag and `req_cpu`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_write | input | 1 | 1 for write |
| req_wdata | input | 32 | Write data, right-aligned |
| req_cpu | input | 1 | Requesting processor ID |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, valid with rsp_valid |
| tgt_strobe | output | 1 | Target cycle strobe |
| tgt_sel | output | 10 | One-hot target select |
| tgt_offs | output | OFFS_W (22) | Masked target offset |
| tgt_write | output | 1 | Target cycle is a write |
| tgt_be | output | 2 | Byte lanes, bit 1 is bits 15:8 |
| tgt_wide | output | 1 | Native 32-bit peripheral cycle |
| tgt_wdata | output | 32 | Target write data |
| tgt_cpu | output | 1 | Processor ID passed to targets |
| tgt_rdata | input | 32 | Target read data, LAT cycles after strobe |

## Verification
The sweep covers all 32 regions at both settings of address bits 28:27. If an alias pair were decoded apart, or the wrong address bits fed the region index, the select or offset would differ in some region. The second-level sweep steps addr[17:8] across 0x3F..0x44 and some far values. If the palette write window were decoded on all ten bits, writes at 0x43xx would be lost. If the read window were widened, reads at 0x43xx would reach palette rather than boot ROM. Odd and even byte addresses expose a swapped lane. Word accesses show a missing split, a split that is also applied to peripherals, swapped halves, or a wrong response latency.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int N_TGT = 10;
  localparam int T_BOOT = 0;
  localparam int T_SYS  = 1;
  localparam int T_VID  = 2;
  localparam int T_PAL  = 3;
  localparam int T_CART = 4;
  localparam int T_FB   = 5;
  localparam int T_SD   = 6;
  localparam int T_DA0  = 7;
  localparam int T_DA1  = 8;
  localparam int T_PER  = 9;

  localparam logic [4:0] REG_DA  = 5'h18;
  localparam logic [4:0] REG_PER = 5'h1F;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} state_e;

  typedef struct packed {
    logic [31:0] addr;
    logic        write;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        cpu;
  } req_t;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/brd_region_map.sv
module brd_region_map
  import brd_pkg::*;
#(
  parameter int BOOT_AW = 14,
  parameter int REG_AW  = 8,
  parameter int PAL_AW  = 9,
  parameter int CART_AW = 22,
  parameter int FB_AW   = 17,
  parameter int SD_AW   = 18,
  parameter int DA_AW   = 12,
  parameter int PER_AW  = 9,
  parameter int OFFS_W  = 22
) (
  input  logic [31:0]       addr,
  input  logic              write,
  input  logic              cpu,
  output logic [N_TGT-1:0]  sel,
  output logic [OFFS_W-1:0] offs,
  output logic              periph
);
  localparam int AW [N_TGT] = '{BOOT_AW, REG_AW, REG_AW, PAL_AW, CART_AW,
                                FB_AW, SD_AW, DA_AW, DA_AW, PER_AW};

  logic [4:0] region;
  logic [9:0] sub;
  logic [OFFS_W-1:0] masked [N_TGT];
  logic unused_addr;

  assign region = {addr[31:29], addr[26:25]};
  assign sub    = addr[17:8];
  assign periph = (region == REG_PER);
  assign unused_addr = ^{addr[28:27]};

  // first level on the region index, second level inside chip select 0
  always_comb begin
    sel = '0;
    if (region[4:3] == 2'b00) begin
      unique case (region[1:0])
        2'd0: begin
          if (sub == 10'h040)                                     sel[T_SYS]  = 1'b1;
          else if (sub == 10'h041)                                sel[T_VID]  = 1'b1;
          else if (write ? (sub[9:1] == 9'h021) : (sub == 10'h042)) sel[T_PAL] = 1'b1;
          else if (!write)                                        sel[T_BOOT] = 1'b1;
        end
        2'd1: if (!write) sel[T_CART] = 1'b1;
        2'd2: sel[T_FB] = 1'b1;
        default: sel[T_SD] = 1'b1;
      endcase
    end else if (region == REG_DA) begin
      if (cpu) sel[T_DA1] = 1'b1;
      else     sel[T_DA0] = 1'b1;
    end else if (region == REG_PER) begin
      sel[T_PER] = 1'b1;
    end
  end

  for (genvar g = 0; g < N_TGT; g++) begin : g_mask
    localparam logic [OFFS_W-1:0] MASK = OFFS_W'((64'd1 << AW[g]) - 64'd1);
    assign masked[g] = addr[OFFS_W-1:0] & MASK;
  end

  always_comb begin
    offs = '0;
    for (int i = 0; i < N_TGT; i++)
      if (sel[i]) offs = offs | masked[i];
  end
endmodule

// File: rtl/brd_lane.sv
module brd_lane (
  input  logic [1:0]  size,
  input  logic        a0,
  input  logic        half,
  input  logic        wide,
  input  logic [31:0] wdata,
  input  logic [31:0] rdata,
  input  logic [31:0] acc,
  output logic [1:0]  be,
  output logic [31:0] tgt_wdata,
  output logic [31:0] acc_next
);
  // big-endian: even byte address lives on bits 15:8
  always_comb begin
    if (wide) begin
      be        = 2'b11;
      tgt_wdata = wdata;
      acc_next  = rdata;
    end else if (size[1]) begin
      be        = 2'b11;
      tgt_wdata = {16'h0, half ? wdata[15:0] : wdata[31:16]};
      acc_next  = half ? {acc[31:16], rdata[15:0]} : {rdata[15:0], acc[15:0]};
    end else if (size[0]) begin
      be        = 2'b11;
      tgt_wdata = {16'h0, wdata[15:0]};
      acc_next  = {16'h0, rdata[15:0]};
    end else begin
      be        = a0 ? 2'b01 : 2'b10;
      tgt_wdata = {16'h0, wdata[7:0], wdata[7:0]};
      acc_next  = {24'h0, a0 ? rdata[7:0] : rdata[15:8]};
    end
  end
endmodule

// File: rtl/brd_seq.sv
module brd_seq
  import brd_pkg::*;
#(
  parameter int LAT = 2,
  localparam int CNT_W = $clog2(LAT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  req_t        req_in,
  input  logic        mapped,
  input  logic        split,
  input  logic [31:0] acc_next,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic        strobe,
  output req_t        q,
  output logic        half,
  output logic [31:0] acc
);
  state_e           state;
  logic [CNT_W-1:0] cnt;

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);
  assign strobe    = (state == ST_ISSUE) && mapped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      q     <= '0;
      half  <= 1'b0;
      cnt   <= '0;
      acc   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          q     <= req_in;
          half  <= 1'b0;
          acc   <= '0;
          state <= ST_ISSUE;
        end
        ST_ISSUE: begin
          cnt   <= '0;
          state <= mapped ? ST_WAIT : ST_DONE;
        end
        ST_WAIT: begin
          if (cnt == CNT_W'(LAT - 1)) begin
            if (!q.write) acc <= acc_next;
            if (split && !half) begin
              half  <= 1'b1;
              state <= ST_ISSUE;
            end else begin
              state <= ST_DONE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_strobe_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder
  import brd_pkg::*;
#(
  parameter int LAT     = 2,
  parameter int BOOT_AW = 14,
  parameter int REG_AW  = 8,
  parameter int PAL_AW  = 9,
  parameter int CART_AW = 22,
  parameter int FB_AW   = 17,
  parameter int SD_AW   = 18,
  parameter int DA_AW   = 12,
  parameter int PER_AW  = 9,
  localparam int OFFS_W = max_int(max_int(max_int(BOOT_AW, REG_AW), max_int(PAL_AW, CART_AW)),
                                  max_int(max_int(FB_AW, SD_AW), max_int(DA_AW, PER_AW)))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  input  logic              req_cpu,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              tgt_strobe,
  output logic [N_TGT-1:0]  tgt_sel,
  output logic [OFFS_W-1:0] tgt_offs,
  output logic              tgt_write,
  output logic [1:0]        tgt_be,
  output logic              tgt_wide,
  output logic [31:0]       tgt_wdata,
  output logic              tgt_cpu,
  input  logic [31:0]       tgt_rdata
);
  req_t              req_in, q;
  logic              half, periph, mapped, split, wide;
  logic [31:0]       cyc_addr, acc, acc_next;
  logic [OFFS_W-1:0] map_offs;

  assign req_in = '{addr: req_addr, write: req_write, size: req_size,
                    wdata: req_wdata, cpu: req_cpu};

  // word accesses walk the two halfwords of the aligned word
  assign cyc_addr = q.size[1] ? {q.addr[31:2], half, 1'b0} : q.addr;
  assign wide     = q.size[1] && periph;
  assign split    = q.size[1] && !periph;
  assign mapped   = |tgt_sel;

  brd_seq #(.LAT(LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_in(req_in),
    .mapped(mapped), .split(split), .acc_next(acc_next),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .strobe(tgt_strobe),
    .q(q), .half(half), .acc(acc)
  );

  brd_region_map #(
    .BOOT_AW(BOOT_AW), .REG_AW(REG_AW), .PAL_AW(PAL_AW), .CART_AW(CART_AW),
    .FB_AW(FB_AW), .SD_AW(SD_AW), .DA_AW(DA_AW), .PER_AW(PER_AW), .OFFS_W(OFFS_W)
  ) u_map (
    .addr(cyc_addr), .write(q.write), .cpu(q.cpu),
    .sel(tgt_sel), .offs(map_offs), .periph(periph)
  );

  brd_lane u_lane (
    .size(q.size), .a0(q.addr[0]), .half(half), .wide(wide),
    .wdata(q.wdata), .rdata(tgt_rdata), .acc(acc),
    .be(tgt_be), .tgt_wdata(tgt_wdata), .acc_next(acc_next)
  );

  assign tgt_offs  = map_offs & ~OFFS_W'(wide ? 2'd3 : 2'd1);
  assign tgt_write = q.write;
  assign tgt_cpu   = q.cpu;
  assign tgt_wide  = wide;
  assign rsp_rdata = acc;

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_strobe |-> $countones(tgt_sel) == 1);
  p_rom_write_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_strobe && tgt_write) |-> !(tgt_sel[T_BOOT] || tgt_sel[T_CART]));
  p_wide_periph_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_strobe && tgt_wide) |-> tgt_sel[T_PER]);
  p_offs_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_strobe |-> !tgt_offs[0]);
  p_ready_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!tgt_strobe && !rsp_valid));
endmodule

// File: tb/bus_region_decoder_bench.sv
module bus_region_decoder_bench;
  localparam int LAT = 2;
  localparam int AWS [10] = '{14, 8, 8, 9, 22, 17, 18, 12, 12, 9};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, req_cpu;
  logic [31:0] req_addr, req_wdata, rsp_rdata, tgt_wdata, tgt_rdata;
  logic [1:0]  req_size, tgt_be;
  logic        rsp_valid, tgt_strobe, tgt_write, tgt_wide, tgt_cpu;
  logic [9:0]  tgt_sel;
  logic [21:0] tgt_offs;

  int n_chk = 0;
  int n_err = 0;
  bit ended = 0;

  bus_region_decoder #(.LAT(LAT)) u_bus_region_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .req_cpu(req_cpu), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .tgt_strobe(tgt_strobe), .tgt_sel(tgt_sel),
    .tgt_offs(tgt_offs), .tgt_write(tgt_write), .tgt_be(tgt_be),
    .tgt_wide(tgt_wide), .tgt_wdata(tgt_wdata), .tgt_cpu(tgt_cpu),
    .tgt_rdata(tgt_rdata)
  );

  function automatic int sel_idx(input logic [9:0] s);
    for (int i = 0; i < 10; i++) if (s[i]) return i;
    return 0;
  endfunction

  function automatic logic [15:0] stub16(input int t, input logic [21:0] o, input logic cpu);
    return {4'(t), 4'h5, 8'h00} ^ o[15:0] ^ (cpu ? 16'h3C00 : 16'h0000);
  endfunction

  // target stub with fixed read latency
  logic [31:0] pipe [LAT];
  always @(posedge clk) begin
    logic [15:0] lo;
    lo = stub16(sel_idx(tgt_sel), tgt_offs, tgt_cpu);
    if (tgt_strobe) pipe[0] <= tgt_wide ? {~lo, lo} : {16'hDEAD, lo};
    else            pipe[0] <= 32'hBAD0BAD0;
    for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
  end
  assign tgt_rdata = pipe[LAT-1];

  logic [9:0]  lg_sel [4];
  logic [21:0] lg_offs [4];
  logic [31:0] lg_wd [4];
  logic [1:0]  lg_be [4];
  logic        lg_wr [4], lg_wide [4], lg_cpu [4];
  int          lg_n;
  always @(negedge clk) if (tgt_strobe) begin
    if (lg_n < 4) begin
      lg_sel[lg_n] = tgt_sel;  lg_offs[lg_n] = tgt_offs; lg_wd[lg_n] = tgt_wdata;
      lg_be[lg_n]  = tgt_be;   lg_wr[lg_n]   = tgt_write; lg_wide[lg_n] = tgt_wide;
      lg_cpu[lg_n] = tgt_cpu;
    end
    lg_n = lg_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int e_tgt(input logic [31:0] a, input bit wr, input bit cpu);
    logic [4:0] r;
    logic [9:0] s;
    r = {a[31:29], a[26:25]};
    s = a[17:8];
    if (r < 5'd8) begin
      case (r[1:0])
        2'd0: begin
          if (s == 10'h040) return 1;
          if (s == 10'h041) return 2;
          if (wr) return (s == 10'h042 || s == 10'h043) ? 3 : -1;
          return (s == 10'h042) ? 3 : 0;
        end
        2'd1: return wr ? -1 : 4;
        2'd2: return 5;
        default: return 6;
      endcase
    end
    if (r == 5'h18) return cpu ? 8 : 7;
    if (r == 5'h1F) return 9;
    return -1;
  endfunction

  function automatic logic [21:0] e_offs(input int t, input logic [31:0] a, input bit wide);
    logic [21:0] m;
    m = 22'((64'd1 << AWS[t]) - 64'd1);
    return a[21:0] & m & (wide ? 22'h3FFFFC : 22'h3FFFFE);
  endfunction

  task automatic run(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                     input bit cpu, input string tag);
    int t, nexp, c, elat;
    bit word, wide;
    string ltag;
    logic [31:0] w, cyc, erd;
    logic [15:0] lo [2];
    logic [21:0] eo;
    t = e_tgt(a, wr, cpu);
    word = sz[1];
    wide = word && (t == 9);
    nexp = (t < 0) ? 0 : ((word && !wide) ? 2 : 1);
    elat = (t < 0) ? 1 : nexp * (LAT + 1);
    ltag = wide ? "R10" : (word ? "R9" : (sz[0] ? "R8" : "R7"));
    w = {a[15:0] ^ 16'h9A3C, a[31:16] ^ 16'h5E71};
    lg_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_wdata = w; req_cpu = cpu;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R12", "ready while busy", 32'(req_ready), 0);
    c = 0;
    while (!rsp_valid && c < 100) begin
      @(negedge clk);
      c++;
    end
    chk(c == elat, "R11", "response latency", c, elat);
    for (int k = 0; k < 2; k++) begin
      cyc = (word && !wide) ? {a[31:2], k[0], 1'b0} : a;
      lo[k] = (t < 0) ? 16'h0 : stub16(t, e_offs(t, cyc, wide), cpu);
    end
    if (wr || t < 0) erd = 32'h0;
    else if (wide) erd = {~lo[0], lo[0]};
    else if (word) erd = {lo[0], lo[1]};
    else if (sz[0]) erd = {16'h0, lo[0]};
    else erd = {24'h0, a[0] ? lo[0][7:0] : lo[0][15:8]};
    chk(rsp_rdata == erd, (t < 0) ? "R6" : ltag, "read data", rsp_rdata, erd);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12", "response pulse", 32'(rsp_valid), 0);
    chk(lg_n == nexp, (nexp == 2) ? "R9" : tag, "strobe count", lg_n, nexp);
    for (int k = 0; k < nexp && k < lg_n; k++) begin
      cyc = (word && !wide) ? {a[31:2], k[0], 1'b0} : a;
      eo = e_offs(t, cyc, wide);
      chk(lg_sel[k] == 10'(1 << t), tag, "target select", 32'(lg_sel[k]), 32'(1 << t));
      chk(lg_offs[k] == eo, tag, "offset", 32'(lg_offs[k]), 32'(eo));
      chk(lg_wr[k] == wr && lg_cpu[k] == cpu, "R12", "write/cpu",
          {lg_wr[k], lg_cpu[k]}, {wr, cpu});
      chk(lg_wide[k] == wide, "R10", "wide flag", 32'(lg_wide[k]), 32'(wide));
      if (!word && !sz[0]) begin
        chk(lg_be[k] == (a[0] ? 2'b01 : 2'b10), "R7", "byte enables",
            32'(lg_be[k]), a[0] ? 1 : 2);
        chk(lg_wd[k] == {16'h0, w[7:0], w[7:0]}, "R7", "byte write data",
            lg_wd[k], {16'h0, w[7:0], w[7:0]});
      end else begin
        chk(lg_be[k] == 2'b11, ltag, "byte enables", 32'(lg_be[k]), 3);
        if (wide)
          chk(lg_wd[k] == w, "R10", "wide write data", lg_wd[k], w);
        else if (word)
          chk(lg_wd[k] == {16'h0, (k == 0) ? w[31:16] : w[15:0]}, "R9", "split write data",
              lg_wd[k], {16'h0, (k == 0) ? w[31:16] : w[15:0]});
        else
          chk(lg_wd[k] == {16'h0, w[15:0]}, "R8", "half write data", lg_wd[k], {16'h0, w[15:0]});
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [24:0] pats [3];
    logic [9:0]  subs [8];
    logic [7:0]  lows [2];
    pats = '{25'h0123457, 25'h1ABCDE6, 25'h0055AA8};
    subs = '{10'h03F, 10'h040, 10'h041, 10'h042, 10'h043, 10'h044, 10'h140, 10'h242};
    lows = '{8'h3B, 8'hC4};
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_write = 1'b0; req_wdata = '0; req_cpu = 1'b0; lg_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && tgt_strobe == 1'b0, "R12", "reset state",
        {req_ready, rsp_valid, tgt_strobe}, 3'b100);

    // all regions, alias bits 28:27 varied
    for (int idx = 0; idx < 32; idx++)
      for (int v = 0; v < 3; v++)
        for (int sz = 0; sz < 3; sz++)
          for (int wr = 0; wr < 2; wr++)
            for (int cpu = 0; cpu < 2; cpu++) begin
              logic [4:0] r;
              logic [31:0] a;
              int t;
              string tag;
              r = 5'(idx);
              a = {r[4:2], (v == 1) ? 2'b11 : 2'(v), r[1:0], pats[v]};
              t = e_tgt(a, wr[0], cpu[0]);
              if (wr != 0 && t < 0 && r < 5'd8) tag = "R5";
              else if (t < 0) tag = "R6";
              else if (r >= 5'd4 && r < 5'd8) tag = "R1";
              else tag = "R2";
              run(a, 2'(sz), wr[0], cpu[0], tag);
            end

    // second level inside chip select 0 and its alias
    for (int al = 0; al < 2; al++)
      for (int si = 0; si < 8; si++)
        for (int li = 0; li < 2; li++)
          for (int sz = 0; sz < 4; sz++)
            for (int wr = 0; wr < 2; wr++) begin
              logic [31:0] a;
              int t;
              string tag;
              a = {(al != 0) ? 3'b001 : 3'b000, 2'b01, 2'b00, 7'h2A, subs[si], lows[li]};
              t = e_tgt(a, wr[0], li[0]);
              if (wr != 0 && t < 0) tag = "R5";
              else if (wr != 0 && t == 3) tag = "R4";
              else tag = "R3";
              run(a, 2'(sz), wr[0], li[0], tag);
            end

    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule